// File: doc/BRIEF.md
# Power-On and Low-Voltage Reset Sequencer

This block generates the internal reset for a small microcontroller. Two causes feed it. The first is an active-low power-on flag, which also serves as the block's own asynchronous reset. The second is an active-high flag from the supply comparator that reports the supply is below its threshold. Both causes share one release counter. The internal reset stays asserted until the cause has been gone for a fixed number of clock cycles, and is then released on a clock edge.

Software arms and disarms low-voltage reset through a three-bit control register, written over a single-cycle write strobe. The register holds a detector-enable bit, a reset-enable bit and a threshold-select bit. Arming takes two steps. Software first sets detector-enable, then sets reset-enable in a later write. The block honours reset-enable only after a stabilisation wait that it times itself from the clock frequency. Disarming runs in the reverse order, and the block refuses any write that would drop detector-enable while reset-enable is still set. A low-voltage reset keeps the register contents. Only power-on clears them. A status output reports which cause produced the last reset.

Top module: `lvr_seq`

## Requirements
- R1: While rst_ni is low, rst_no is low (asserted without waiting for a clock edge), ctrl_o is 0, err_o is 0 and cause_o is 0 (power-on).
- R2: After rst_ni rises, rst_no stays low through the first REL_CYC-1 rising clock edges and goes high at rising edge number REL_CYC.
- R3: When low-voltage reset is armed and lv_i rises, rst_no goes low at the third rising edge after the change, and cause_o becomes 1 (low voltage).
- R4: While lv_i stays high, the release counter is held at zero. After lv_i falls, rst_no goes high at rising edge number REL_CYC+2.
- R5: A low-voltage reset leaves ctrl_o unchanged.
- R6: ctrl_o bit 0 is detector-enable, bit 1 is reset-enable and bit 2 is threshold-select. A write sets bit 1 only if it keeps bit 0 set and bit 0 was already set before that write. Otherwise bit 1 becomes 0.
- R7: Once detector-enable is set, lv_i cannot cause a reset until STAB_CYC = CLK_HZ/1e6*STAB_US rising edges have passed.
- R8: A write with bit 0 clear while reset-enable is set is illegal. It leaves ctrl_o unchanged and sets err_o, which stays set until power-on. A write clearing reset-enable while keeping detector-enable, followed by a write clearing detector-enable, is legal and leaves err_o clear.
- R9: With reset-enable clear, lv_i has no effect on rst_no or cause_o.
- R10: thr_sel_o always equals ctrl_o bit 2.
- R11: Pulling rst_ni low during a low-voltage reset clears ctrl_o and cause_o and restarts the release count as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on flag, active low, asynchronous |
| lv_i | input | 1 | Supply-below-threshold flag, asynchronous |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 3 | Control register write data |
| ctrl_o | output | 3 | Control register readback |
| err_o | output | 1 | Sticky illegal-disarm flag |
| cause_o | output | 1 | Last reset cause: 0 power-on, 1 low voltage |
| thr_sel_o | output | 1 | Threshold select to the comparator |
| rst_no | output | 1 | Internal reset, active low |

## Verification
The bench sweeps all eight write values against each of the three reachable register states: idle, detector on, and armed. This separates writes that are accepted, writes that have reset-enable masked off, and illegal disarms. Low-voltage pulses are applied in three settings: armed, detector-only, and inside the stabilisation window. Together they distinguish a correct arming gate from one that ignores reset-enable or the wait. Release timing is measured edge by edge after power-on, after supply recovery and after power-on during a low-voltage reset. This exposes off-by-one errors in the counter and in the synchroniser latency.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int CTRL_W = 3;

  typedef struct packed {
    logic thr_sel;
    logic rst_en;
    logic det_en;
  } lvr_ctrl_t;

  typedef enum logic {
    CAUSE_POR = 1'b0,
    CAUSE_LV  = 1'b1
  } lvr_cause_e;
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/lvr_ctrl_reg.sv
module lvr_ctrl_reg
  import lvr_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STAB_US = 50
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  lvr_ctrl_t wd_i,
  output lvr_ctrl_t ctrl_o,
  output logic      err_o,
  output logic      armed_o
);
  localparam int STAB_RAW = (CLK_HZ / 1_000_000) * STAB_US;
  localparam int STAB_CYC = (STAB_RAW < 1) ? 1 : STAB_RAW;
  localparam int STAB_W   = $clog2(STAB_CYC + 1);

  lvr_ctrl_t        ctrl_q;
  logic             err_q;
  logic [STAB_W-1:0] stab_q;
  logic             stab_done;
  logic             illegal;

  // detector may not be dropped while reset-enable is still set
  assign illegal = wr_en_i && ctrl_q.rst_en && !wd_i.det_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (illegal) begin
        err_q <= 1'b1;
      end else begin
        ctrl_q.det_en  <= wd_i.det_en;
        ctrl_q.thr_sel <= wd_i.thr_sel;
        ctrl_q.rst_en  <= wd_i.rst_en && wd_i.det_en && ctrl_q.det_en;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stab_q <= '0;
    else if (!ctrl_q.det_en)    stab_q <= '0;
    else if (!stab_done)        stab_q <= stab_q + 1'b1;
  end

  assign stab_done = (stab_q == STAB_W'(STAB_CYC));
  assign ctrl_o    = ctrl_q;
  assign err_o     = err_q;
  assign armed_o   = ctrl_q.det_en && ctrl_q.rst_en && stab_done;
endmodule

// File: rtl/lvr_rel_cnt.sv
module lvr_rel_cnt
  import lvr_pkg::*;
#(
  parameter int REL_CYC = 131072
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lv_hit_i,
  output logic       rst_no,
  output lvr_cause_e cause_o
);
  localparam int CNT_W = $clog2(REL_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             rel_q;
  lvr_cause_e       cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rel_q   <= 1'b0;
      cause_q <= CAUSE_POR;
    end else if (lv_hit_i) begin
      cnt_q   <= '0;
      rel_q   <= 1'b0;
      cause_q <= CAUSE_LV;
    end else if (!rel_q) begin
      if (cnt_q == CNT_W'(REL_CYC - 1)) rel_q <= 1'b1;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_no  = rel_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/lvr_seq.sv
module lvr_seq
  import lvr_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STAB_US = 50,
  parameter int REL_CYC = 131072
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lv_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              err_o,
  output logic              cause_o,
  output logic              thr_sel_o,
  output logic              rst_no
);
  lvr_ctrl_t  ctrl;
  lvr_cause_e cause;
  logic       lv_s;
  logic       armed;

  lvr_sync #(.STAGES(2)) i_lv_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lv_i),
    .q_o   (lv_s)
  );

  lvr_ctrl_reg #(.CLK_HZ(CLK_HZ), .STAB_US(STAB_US)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .wd_i   (lvr_ctrl_t'(wr_data_i)),
    .ctrl_o (ctrl),
    .err_o  (err_o),
    .armed_o(armed)
  );

  lvr_rel_cnt #(.REL_CYC(REL_CYC)) i_rel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lv_hit_i(armed && lv_s),
    .rst_no  (rst_no),
    .cause_o (cause)
  );

  assign ctrl_o    = ctrl;
  assign thr_sel_o = ctrl.thr_sel;
  assign cause_o   = cause;
endmodule

// File: rtl/lvr_seq_chk.sv
module lvr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_data_i,
  input logic [2:0] ctrl_o,
  input logic       err_o,
  input logic       cause_o,
  input logic       rst_no,
  input logic       armed,
  input logic       lv_s
);
  assert_ctrl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o));

  assert_rst_en_needs_det_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1] |-> ctrl_o[0]);

  assert_illegal_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_o[1] && !wr_data_i[0]) |=> ($stable(ctrl_o) && err_o));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_lv_holds_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && lv_s) |=> !rst_no);

  assert_cause_with_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o) |-> !rst_no);
endmodule

bind lvr_seq lvr_seq_chk i_lvr_seq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .ctrl_o   (ctrl_o),
  .err_o    (err_o),
  .cause_o  (cause_o),
  .rst_no   (rst_no),
  .armed    (armed),
  .lv_s     (lv_s)
);

// File: tb/test_lvr_seq.sv
module test_lvr_seq;
  localparam int REL  = 16;
  localparam int HZ   = 1_000_000;
  localparam int US   = 8;
  localparam int STAB = (HZ / 1_000_000) * US;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       lv_i;
  logic       wr_en_i;
  logic [2:0] wr_data_i;
  logic [2:0] ctrl_o;
  logic       err_o, cause_o, thr_sel_o, rst_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  lvr_seq #(.CLK_HZ(HZ), .STAB_US(US), .REL_CYC(REL)) i_lvr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lv_i(lv_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .err_o(err_o), .cause_o(cause_o),
    .thr_sel_o(thr_sel_o), .rst_no(rst_no)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      #5;
    end
  endtask

  task automatic wr(logic [2:0] v);
    wr_en_i   = 1'b1;
    wr_data_i = v;
    tick();
    wr_en_i   = 1'b0;
  endtask

  task automatic por();
    rst_ni = 1'b0;
    lv_i   = 1'b0;
    tick(2);
    chk("R1 rst_no", rst_no, 0);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 cause", cause_o, 0);
    rst_ni = 1'b1;
    tick(REL - 1);
    chk("R2 held", rst_no, 0);
    tick();
    chk("R2 released", rst_no, 1);
  endtask

  task automatic arm();
    wr(3'b001);
    tick(STAB + 2);
    wr(3'b011);
  endtask

  function automatic logic [3:0] model(logic [2:0] cur, logic [2:0] v);
    logic ill;
    ill = cur[1] && !v[0];
    if (ill) return {1'b1, cur};
    return {1'b0, v[2], v[1] & v[0] & cur[0], v[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni    = 1'b0;
    lv_i      = 1'b0;
    wr_en_i   = 1'b0;
    wr_data_i = '0;
    por();

    // R1: assertion without a clock edge
    #3 rst_ni = 1'b0;
    #1 chk("R1 async assert", rst_no, 0);
    tick();
    por();

    // R6/R8/R10: write sweep over three reachable states
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 8; v++) begin
        logic [2:0] cur;
        logic [3:0] exp;
        por();
        cur = 3'b000;
        if (s >= 1) begin wr(3'b001); cur = 3'b001; end
        if (s == 2) begin wr(3'b011); cur = 3'b011; end
        exp = model(cur, 3'(v));
        wr(3'(v));
        chk($sformatf("R6 ctrl s=%0d v=%0d", s, v), ctrl_o, exp[2:0]);
        chk($sformatf("R8 err s=%0d v=%0d", s, v), err_o, exp[3]);
        chk($sformatf("R10 thr s=%0d v=%0d", s, v), thr_sel_o, ctrl_o[2]);
      end
    end

    // R8: legal disarm order, then stickiness
    por();
    arm();
    wr(3'b001);
    chk("R8 disarm step1", ctrl_o, 3'b001);
    wr(3'b000);
    chk("R8 disarm step2", ctrl_o, 3'b000);
    chk("R8 legal no err", err_o, 0);
    arm();
    wr(3'b100);
    chk("R8 illegal kept", ctrl_o, 3'b011);
    wr(3'b111);
    chk("R8 err sticky", err_o, 1);

    // R3/R4/R5: armed low-voltage reset
    por();
    wr(3'b101);
    tick(STAB + 2);
    wr(3'b111);
    lv_i = 1'b1;
    tick(2);
    chk("R3 not yet", rst_no, 1);
    tick();
    chk("R3 asserted", rst_no, 0);
    chk("R3 cause lv", cause_o, 1);
    tick(3 * REL);
    chk("R4 held while low", rst_no, 0);
    chk("R5 ctrl kept", ctrl_o, 3'b111);
    lv_i = 1'b0;
    tick(REL + 1);
    chk("R4 held edge", rst_no, 0);
    tick();
    chk("R4 released", rst_no, 1);
    chk("R5 ctrl after", ctrl_o, 3'b111);
    chk("R3 cause stays", cause_o, 1);

    // R7: stabilisation window boundary
    por();
    wr(3'b001);
    wr(3'b011);
    lv_i = 1'b1;
    tick(STAB - 1);
    chk("R7 inside wait", rst_no, 1);
    tick();
    chk("R7 after wait", rst_no, 0);
    lv_i = 1'b0;
    tick(REL + 2);
    chk("R7 recovered", rst_no, 1);

    // R9: detector only, no reset-enable
    por();
    wr(3'b001);
    tick(STAB + 2);
    lv_i = 1'b1;
    tick(10);
    chk("R9 no reset", rst_no, 1);
    chk("R9 cause por", cause_o, 0);
    lv_i = 1'b0;

    // R11: power-on during a low-voltage reset
    por();
    arm();
    lv_i = 1'b1;
    tick(4);
    chk("R11 in lv reset", rst_no, 0);
    por();
    chk("R11 ctrl cleared", ctrl_o, 0);
    chk("R11 cause por", cause_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule